// File: doc/BRIEF.md
# Scaler Initial Phase Calculator

This block computes the starting filter phase for one axis of a polyphase image scaler. It takes an unsigned 16.16 fixed-point step, which is the source size divided by the destination size. It also takes a subsampling factor of 1 or 2 and a flag that asks for co-sited chroma. From these it forms a signed intermediate phase and packs it into a 16-bit phase word that a scaler datapath can load.

The phase is measured from the top or left edge of the first pixel, not from its centre, so the calculation starts half a pixel back. Half the per-output step, divided by the subsampling factor, is then added. With co-siting on a 2:1 subsampled plane, a further quarter pixel is added. A phase below zero is wrapped modulo one pixel and its trip bit stays clear. A phase of zero or more sets the trip bit.

An intermediate phase outside the permitted window raises an error flag. An unsupported subsampling factor does the same. The block has one register stage: a request marked valid on one clock edge gives its result after that edge.

Top module: `init_phase_calc`

## Requirements
- R1: While reset is held, out_valid, phase_word and range_err are all 0.
- R2: A request sampled with in_valid high on a rising edge drives out_valid high after that edge. Without a new request, out_valid returns to 0 and phase_word and range_err keep their last values.
- R3: The intermediate phase, in units of 2^-16 pixel, is -32768, plus floor(scale_in/4) when sub_sel is 2 or floor(scale_in/2) when sub_sel is 1, plus 16384 when cosite is 1 and sub_sel is 2.
- R4: An in-window phase P of 0 or more gives trip bit 14 = 1 and bits [13:0] = floor(P/4) mod 16384.
- R5: An in-window phase P below 0 gives trip bit 14 = 0 and bits [13:0] = floor((P+65536)/4) mod 16384.
- R6: A phase outside -32768..98304 (inclusive) sets range_err, and phase_word is then 0.
- R7: A sub_sel value other than 1 or 2 (that is, 0 or 3) sets range_err with phase_word 0.
- R8: Bit 15 of phase_word is always 0.
- R9: With sub_sel = 1, cosite has no effect on the result.
- R10: A 4:1 downscale (scale_in 0x40000, sub_sel 1) gives 0x6000, a phase of 1.5 pixel. A 1:4 upscale (scale_in 0x4000, sub_sel 1) gives 0x2800, a phase of -0.375 pixel wrapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Request strobe; loads a new result |
| scale_in | input | 32 | Unsigned 16.16 scale step (source over destination) |
| sub_sel | input | 2 | Subsampling factor; 1 and 2 are legal |
| cosite | input | 1 | Co-sited chroma offset request |
| out_valid | output | 1 | Result updated on the previous edge |
| phase_word | output | 16 | Bit 14 trip, bits [13:0] phase fraction, bit 15 zero |
| range_err | output | 1 | Phase out of window or illegal sub_sel |

## Verification
Some properties are checked on every cycle: the one-cycle result timing and hold behaviour, the zero word on any error, the error raised by an illegal subsampling code, the cleared spare bit, and the fact that a cleared trip bit always comes with a fraction in the upper half of its range. Other behaviours show only in the bench's arithmetic sweep over step values, subsampling codes and co-siting. These are the exact fraction values, the quarter-pixel co-siting offset, the exact edges of the window, and the two reference scaling cases.

// File: rtl/init_phase_pkg.sv
package init_phase_pkg;
  parameter int unsigned PH_SCALE_W = 32;
  parameter int unsigned PH_FRAC_W  = 16;
  parameter int unsigned PH_FIELD_W = 14;
  parameter int unsigned PH_OUT_W   = 16;
  parameter int unsigned PH_SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    SUB_RSV0 = 2'd0,
    SUB_ONE  = 2'd1,
    SUB_TWO  = 2'd2,
    SUB_RSV3 = 2'd3
  } sub_code_e;
endpackage

// File: rtl/iphase_rst_sync.sv
module iphase_rst_sync #(
  parameter int unsigned STAGES = init_phase_pkg::PH_SYNC_STAGES
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/iphase_sum.sv
module iphase_sum
  import init_phase_pkg::*;
#(
  parameter int unsigned SCALE_W = PH_SCALE_W,
  parameter int unsigned FRAC_W  = PH_FRAC_W,
  localparam int unsigned ACC_W  = SCALE_W + 2
) (
  input  logic [SCALE_W-1:0]      scale_in,
  input  logic [1:0]              sub_sel,
  input  logic                    cosite,
  output logic signed [ACC_W-1:0] phase_s,
  output logic                    sub_bad
);
  localparam logic signed [ACC_W-1:0] HALF_S    = ACC_W'(1) <<< (FRAC_W - 1);
  localparam logic signed [ACC_W-1:0] QUARTER_S = ACC_W'(1) <<< (FRAC_W - 2);

  logic signed [ACC_W-1:0] step_s;
  logic signed [ACC_W-1:0] site_s;
  logic                    is_two;

  always_comb begin
    is_two  = (sub_code_e'(sub_sel) == SUB_TWO);
    sub_bad = !((sub_code_e'(sub_sel) == SUB_ONE) || is_two);
    if (is_two) step_s = $signed(ACC_W'(scale_in >> 2));
    else        step_s = $signed(ACC_W'(scale_in >> 1));
    site_s  = (cosite && is_two) ? QUARTER_S : '0;
    phase_s = step_s + site_s - HALF_S;
  end
endmodule

// File: rtl/iphase_pack.sv
module iphase_pack
  import init_phase_pkg::*;
#(
  parameter int unsigned ACC_W   = PH_SCALE_W + 2,
  parameter int unsigned FRAC_W  = PH_FRAC_W,
  parameter int unsigned FIELD_W = PH_FIELD_W,
  parameter int unsigned OUT_W   = PH_OUT_W
) (
  input  logic signed [ACC_W-1:0] phase_s,
  input  logic                    sub_bad,
  output logic [OUT_W-1:0]        word,
  output logic                    err
);
  localparam logic signed [ACC_W-1:0] ONE_S  = ACC_W'(1) <<< FRAC_W;
  localparam logic signed [ACC_W-1:0] HALF_S = ACC_W'(1) <<< (FRAC_W - 1);
  localparam logic signed [ACC_W-1:0] HI_S   = ONE_S + HALF_S;
  localparam logic signed [ACC_W-1:0] LO_S   = -HALF_S;

  logic                    neg;
  logic                    trip;
  logic signed [ACC_W-1:0] wrapped;
  logic [FIELD_W-1:0]      field;

  always_comb begin
    neg     = (phase_s < 0);
    err     = sub_bad || (phase_s > HI_S) || (phase_s < LO_S);
    wrapped = neg ? (phase_s + ONE_S) : phase_s;
    field   = FIELD_W'(wrapped >>> 2);
    trip    = !neg;
    word    = err ? '0 : OUT_W'({trip, field});
  end
endmodule

// File: rtl/init_phase_calc.sv
module init_phase_calc
  import init_phase_pkg::*;
#(
  parameter int unsigned SCALE_W = PH_SCALE_W,
  parameter int unsigned FRAC_W  = PH_FRAC_W,
  parameter int unsigned FIELD_W = PH_FIELD_W,
  parameter int unsigned OUT_W   = PH_OUT_W,
  localparam int unsigned ACC_W  = SCALE_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [SCALE_W-1:0] scale_in,
  input  logic [1:0]         sub_sel,
  input  logic               cosite,
  output logic               out_valid,
  output logic [OUT_W-1:0]   phase_word,
  output logic               range_err
);
  logic                    rst_sync_n;
  logic signed [ACC_W-1:0] phase_s;
  logic                    sub_bad;
  logic [OUT_W-1:0]        word_c;
  logic                    err_c;

  logic                    vld_d, vld_q;
  logic [OUT_W-1:0]        word_d, word_q;
  logic                    err_d, err_q;

  iphase_rst_sync #(.STAGES(PH_SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  iphase_sum #(.SCALE_W(SCALE_W), .FRAC_W(FRAC_W)) u_sum (
    .scale_in (scale_in),
    .sub_sel  (sub_sel),
    .cosite   (cosite),
    .phase_s  (phase_s),
    .sub_bad  (sub_bad)
  );

  iphase_pack #(.ACC_W(ACC_W), .FRAC_W(FRAC_W), .FIELD_W(FIELD_W), .OUT_W(OUT_W)) u_pack (
    .phase_s (phase_s),
    .sub_bad (sub_bad),
    .word    (word_c),
    .err     (err_c)
  );

  always_comb begin
    vld_d  = in_valid;
    word_d = word_q;
    err_d  = err_q;
    if (in_valid) begin
      word_d = word_c;
      err_d  = err_c;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q  <= 1'b0;
      word_q <= '0;
      err_q  <= 1'b0;
    end else begin
      vld_q  <= vld_d;
      word_q <= word_d;
      err_q  <= err_d;
    end
  end

  assign out_valid  = vld_q;
  assign phase_word = word_q;
  assign range_err  = err_q;
endmodule

// File: rtl/init_phase_calc_chk.sv
module init_phase_calc_chk #(
  parameter int unsigned FIELD_W = init_phase_pkg::PH_FIELD_W,
  parameter int unsigned OUT_W   = init_phase_pkg::PH_OUT_W
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             in_valid,
  input logic [1:0]       sub_sel,
  input logic             out_valid,
  input logic [OUT_W-1:0] phase_word,
  input logic             range_err
);
  logic seen_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) seen_q <= 1'b0;
    else             seen_q <= 1'b1;
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_sync_n || !seen_q)
    out_valid == $past(in_valid)); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n || !seen_q)
    !$past(in_valid) |-> ($stable(phase_word) && $stable(range_err))); // R2

  AST_BAD_SUB: assert property (@(posedge clk) disable iff (!rst_sync_n || !seen_q)
    ($past(in_valid) && ($past(sub_sel) == 2'd0 || $past(sub_sel) == 2'd3)) |-> range_err); // R7

  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && range_err) |-> (phase_word == '0)); // R6

  AST_NEG_UPPER: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && !range_err && !phase_word[FIELD_W]) |->
      (phase_word[FIELD_W-1] == 1'b1)); // R5

  AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (phase_word >> (FIELD_W + 1)) == '0); // R8
endmodule

bind init_phase_calc init_phase_calc_chk #(.FIELD_W(FIELD_W), .OUT_W(OUT_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .in_valid   (in_valid),
  .sub_sel    (sub_sel),
  .out_valid  (out_valid),
  .phase_word (phase_word),
  .range_err  (range_err)
);

// File: tb/init_phase_calc_test.sv
`timescale 1ns/1ps
module init_phase_calc_test;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] scale_in;
  logic [1:0]  sub_sel;
  logic        cosite;
  logic        out_valid;
  logic [15:0] phase_word;
  logic        range_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  init_phase_calc uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .scale_in(scale_in),
    .sub_sel(sub_sel), .cosite(cosite), .out_valid(out_valid),
    .phase_word(phase_word), .range_err(range_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (scale 0x%0h sub %0d cosite %0d)",
               req, act, exp, scale_in, sub_sel, cosite);
    end
  endtask

  // Expected result from the requirement arithmetic (R3..R7)
  task automatic model(input longint sc, input int sb, input bit cs,
                       output longint word, output bit err, output string req);
    longint p;
    bit bad;
    p = -32768;
    bad = (sb != 1) && (sb != 2);
    if (sb == 2) begin
      p = p + sc / 4;
      if (cs) p = p + 16384;
    end else begin
      p = p + sc / 2;
    end
    err = bad || (p > 98304) || (p < -32768);
    if (bad) begin word = 0; req = "R7"; end
    else if (err) begin word = 0; req = "R6"; end
    else if (p < 0) begin word = ((p + 65536) / 4) % 16384; req = "R5"; end
    else begin word = 16384 + (p / 4) % 16384; req = "R4"; end
  endtask

  task automatic apply(input logic [31:0] sc, input logic [1:0] sb, input bit cs,
                       input bit hold_chk);
    longint ew;
    bit ee;
    string rq;
    longint w0;
    @(negedge clk);
    in_valid = 1'b1; scale_in = sc; sub_sel = sb; cosite = cs;
    @(negedge clk);
    in_valid = 1'b0;
    model(longint'(sc), int'(sb), cs, ew, ee, rq);
    check("R2 valid", out_valid, 1);
    check(rq, phase_word, ew);
    check({rq, " err"}, range_err, ee);
    check("R8", phase_word[15], 0);
    if (hold_chk) begin
      w0 = phase_word;
      scale_in = ~sc;
      @(negedge clk);
      check("R2 idle", out_valid, 0);
      check("R2 hold", phase_word, w0);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] wa, wb;
    rst_n = 1'b0; in_valid = 1'b0; scale_in = '0; sub_sel = 2'd1; cosite = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 valid", out_valid, 0);
    check("R1 word", phase_word, 0);
    check("R1 err", range_err, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reference cases
    apply(32'h0004_0000, 2'd1, 1'b0, 1'b1);
    check("R10 down4", phase_word, 16'h6000);
    apply(32'h0000_4000, 2'd1, 1'b0, 1'b1);
    check("R10 up4", phase_word, 16'h2800);

    // R3 co-siting quarter offset on 2:1 planes
    apply(32'h0000_8000, 2'd2, 1'b1, 1'b0);
    check("R3 cosite", phase_word, 16'h3800);
    apply(32'h0000_8000, 2'd2, 1'b0, 1'b0);
    check("R3 plain", phase_word, 16'h2800);

    // R6 window edges
    apply(32'h0004_0001, 2'd1, 1'b0, 1'b0);
    check("R6 edge in", range_err, 0);
    apply(32'h0004_0002, 2'd1, 1'b0, 1'b0);
    check("R6 edge out", range_err, 1);
    apply(32'h0007_0003, 2'd2, 1'b1, 1'b0);
    check("R6 edge in cosite", range_err, 0);
    apply(32'h0007_0004, 2'd2, 1'b1, 1'b0);
    check("R6 edge out cosite", range_err, 1);
    apply(32'hFFFF_FFFF, 2'd2, 1'b1, 1'b1);
    check("R6 max", range_err, 1);
    apply(32'h0000_0000, 2'd1, 1'b0, 1'b0);
    check("R5 zero step", phase_word, 16'h2000);

    // R7 illegal subsampling codes
    apply(32'h0001_0000, 2'd0, 1'b0, 1'b0);
    check("R7 sub0", range_err, 1);
    apply(32'h0001_0000, 2'd3, 1'b1, 1'b0);
    check("R7 sub3", range_err, 1);

    // R9 cosite ignored with sub 1
    for (int k = 0; k < 8; k++) begin
      apply(32'h0000_3000 * (k + 1), 2'd1, 1'b0, 1'b0);
      wa = phase_word;
      apply(32'h0000_3000 * (k + 1), 2'd1, 1'b1, 1'b0);
      wb = phase_word;
      check("R9", wb, wa);
    end

    // Sweep: R3 R4 R5 R6 R7
    for (int s = 0; s < 4; s++)
      for (int c = 0; c < 2; c++)
        for (int v = 0; v < 32'h0008_0000; v += 32'h1F3)
          apply(32'(v), 2'(s), c[0], (v % 32'h3E6) == 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule